// File: doc/BRIEF.md
# Power-Fail-Safe Sector Update Sequencer

This block stands between a host that wants to change a few bytes of non-volatile storage and a byte-wide memory that can only be erased a whole sector at a time. A plain erase-then-program update loses the sector if power fails in between. To prevent this, the block routes every change through three reserved sectors near the top of the address space. It first journals the destination sector index. It then builds a complete new image of the destination, with the requested bytes substituted. It sets a commit marker, rewrites the destination from the image, and finally clears the marker.

After every reset the block inspects the commit marker before it accepts any request. If the marker shows that a commit happened but the update did not finish, the block reads back the journaled destination index and completes the rewrite. Erase, program and read commands go out over a valid/ready command port. The block issues each command only after the previous one has signalled completion. A counter of finished updates lets the system track wear on the reserved sectors.

Top module: `fsu_sector_updater`

## Requirements
- R1: During reset and in the first cycle after it, `upd_busy` is 1, `upd_done` and `upd_err` are 0 and `upd_count` is 0. The first memory command after reset reads byte 0 of the marker sector.
- R2: An accepted request produces these commands, in this order: erase the journal sector; program the journal; erase the image sector; alternate reads of the destination with programs of the image; program the marker; erase the destination; alternate reads of the image with programs of the destination; erase the marker, which is the final command.
- R3: After a successful update, each destination byte at offsets `req_off` to `req_off+req_len-1` equals data byte (offset-`req_off`), where data byte k is `req_data[8k+7:8k]`. Every other destination byte keeps its old value. The image sector holds the same content as the destination.
- R4: The commit marker is set by programming 0x00 into byte 0 of the marker sector. That byte reads 0xFF again once the update completes.
- R5: The journal sector stores the destination sector index little-endian in its first ceil(SECT_W/8) bytes, least significant byte at offset 0.
- R6: A request sampled while idle is rejected when its length is 0, its length exceeds MAX_N, `req_off+req_len` exceeds the sector size, or its sector is one of the three reserved ones. A rejection gives a one-cycle `upd_err` pulse and no memory command, and `upd_busy` stays low.
- R7: `upd_busy` rises in the cycle after a request is accepted. `upd_done` is a one-cycle pulse, and `upd_busy` is already low in that cycle.
- R8: `upd_count` increases by one for every finished update, whether requested by the host or resumed after reset.
- R9: If the marker byte read after reset is not 0xFF (0x00 or any partially programmed or erased value), the block reads the journal, erases that destination, copies the image into it and erases the marker. It never programs the journal or image sectors during this recovery.
- R10: If the marker byte reads 0xFF after reset, the block goes idle after that single read and touches no other sector.
- R11: While `upd_busy` is high, including during start-up recovery, a request on the host port is ignored and produces neither `upd_done` nor `upd_err`.
- R12: Operation codes are 0 = read byte, 1 = erase sector, 2 = program byte. At most one command is outstanding at a time. While valid is high and ready is low, the command's code, address and data stay unchanged. The reserved sectors are the top three indices: marker = top-2, journal = top-1, image = top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also models power loss |
| req_valid | input | 1 | Host request strobe, sampled while idle |
| req_sect | input | SECT_W | Destination sector index |
| req_off | input | log2(SECT_BYTES) | First byte offset within the sector |
| req_len | input | log2(MAX_N+1) | Number of bytes to change |
| req_data | input | 8*MAX_N | New bytes, byte k in bits 8k+7:8k |
| upd_busy | output | 1 | Sequencer working (update or recovery) |
| upd_done | output | 1 | One-cycle pulse when a host update finishes |
| upd_err | output | 1 | One-cycle pulse when a request is rejected |
| upd_count | output | CNT_W | Finished updates since reset (saturating) |
| mem_cmd_valid | output | 1 | Command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_op | output | 2 | Operation code |
| mem_cmd_addr | output | SECT_W+log2(SECT_BYTES) | Byte address {sector, offset} |
| mem_cmd_wdata | output | 8 | Program data |
| mem_done | input | 1 | Erase or program finished |
| mem_rvalid | input | 1 | Read data valid, ends a read |
| mem_rdata | input | 8 | Read data |

## Verification
Start-up recovery and a new host request can arrive together. A power cut is forced right after the commit marker has been written. The host then holds a valid request while reset is released, so the request lands inside the resumed rewrite. The bench checks that the request yields neither done nor error, that its target sector stays untouched, that the resumed destination matches the independently computed image, and that the counter reads exactly one. A second cut, placed before the marker is written, shows that an uncommitted update leaves the destination in its old state.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2
    } mem_op_e;

    typedef enum logic [3:0] {
        ST_BOOT   = 4'd0,
        ST_REC_A  = 4'd1,
        ST_IDLE   = 4'd2,
        ST_ER_A   = 4'd3,
        ST_WR_A   = 4'd4,
        ST_ER_D   = 4'd5,
        ST_CP_RD  = 4'd6,
        ST_CP_WR  = 4'd7,
        ST_SET_R  = 4'd8,
        ST_ER_DST = 4'd9,
        ST_BK_RD  = 4'd10,
        ST_BK_WR  = 4'd11,
        ST_ER_R   = 4'd12
    } fsu_state_e;

endpackage

// File: rtl/fsu_patch.sv
module fsu_patch #(
    parameter int OFF_W = 12,
    parameter int LEN_W = 4,
    parameter int MAX_N = 8
) (
    input  logic [OFF_W-1:0]   pos,
    input  logic [OFF_W-1:0]   base,
    input  logic [LEN_W-1:0]   cnt,
    input  logic [MAX_N*8-1:0] bytes_in,
    input  logic [7:0]         old_byte,
    output logic [7:0]         new_byte
);
    localparam int SW = OFF_W + LEN_W + 1;

    logic [MAX_N-1:0] lane_hit;

    for (genvar k = 0; k < MAX_N; k++) begin : g_lane
        assign lane_hit[k] = (SW'(k) < SW'(cnt)) && ((SW'(base) + SW'(k)) == SW'(pos));
    end

    always_comb begin
        new_byte = old_byte;
        for (int k = 0; k < MAX_N; k++) begin
            if (lane_hit[k]) new_byte = bytes_in[k*8 +: 8];
        end
    end

endmodule

// File: rtl/fsu_wear_ctr.sv
module fsu_wear_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bump && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign total = cnt_q;

endmodule

// File: rtl/fsu_sector_updater.sv
module fsu_sector_updater
    import fsu_pkg::*;
#(
    parameter int SECT_W     = 10,
    parameter int SECT_BYTES = 4096,
    parameter int MAX_N      = 8,
    parameter int CNT_W      = 16,
    localparam int OFF_W     = $clog2(SECT_BYTES),
    localparam int ADDR_W    = SECT_W + OFF_W,
    localparam int LEN_W     = $clog2(MAX_N + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SECT_W-1:0]  req_sect,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [MAX_N*8-1:0] req_data,
    output logic               upd_busy,
    output logic               upd_done,
    output logic               upd_err,
    output logic [CNT_W-1:0]   upd_count,
    output logic               mem_cmd_valid,
    input  logic               mem_cmd_ready,
    output logic [1:0]         mem_cmd_op,
    output logic [ADDR_W-1:0]  mem_cmd_addr,
    output logic [7:0]         mem_cmd_wdata,
    input  logic               mem_done,
    input  logic               mem_rvalid,
    input  logic [7:0]         mem_rdata
);
    localparam int A_BYTES = (SECT_W + 7) / 8;
    localparam int DW      = A_BYTES * 8;
    localparam int EW      = OFF_W + LEN_W + 1;
    localparam logic [SECT_W-1:0] SEC_D = '1;
    localparam logic [SECT_W-1:0] SEC_A = SEC_D - 1'b1;
    localparam logic [SECT_W-1:0] SEC_R = SEC_D - 2'd2;
    localparam logic [OFF_W-1:0]  LAST_B = OFF_W'(SECT_BYTES - 1);
    localparam logic [OFF_W-1:0]  LAST_A = OFF_W'(A_BYTES - 1);

    typedef struct packed {
        fsu_state_e         st;
        logic               wt;
        logic [OFF_W-1:0]   idx;
        logic [DW-1:0]      dst;
        logic [OFF_W-1:0]   off;
        logic [LEN_W-1:0]   len;
        logic [MAX_N*8-1:0] dat;
        logic [7:0]         rb;
        logic               host;
        logic               done;
        logic               err;
    } regs_t;

    regs_t       r_d, r_q;
    mem_op_e     op;
    logic [SECT_W-1:0] sec;
    logic [OFF_W-1:0]  boff;
    logic [7:0]  wd, merged;
    logic        fin, bump, bad;
    logic [SECT_W-1:0] dsec;
    logic [EW-1:0]     req_end;

    assign dsec    = r_q.dst[SECT_W-1:0];
    assign req_end = EW'(req_off) + EW'(req_len);
    assign bad     = (req_len == '0) || (EW'(req_len) > EW'(MAX_N)) ||
                     (req_end > EW'(SECT_BYTES)) || (req_sect >= SEC_R);

    fsu_patch #(.OFF_W(OFF_W), .LEN_W(LEN_W), .MAX_N(MAX_N)) u_patch (
        .pos(r_q.idx), .base(r_q.off), .cnt(r_q.len), .bytes_in(r_q.dat),
        .old_byte(r_q.rb), .new_byte(merged)
    );

    fsu_wear_ctr #(.CNT_W(CNT_W)) u_wear (
        .clk(clk), .rst_n(rst_n), .bump(bump), .total(upd_count)
    );

    always_comb begin
        op = OP_READ; sec = SEC_R; boff = '0; wd = 8'hFF;
        unique case (r_q.st)
            ST_REC_A:  begin op = OP_READ;  sec = SEC_A; boff = r_q.idx; end
            ST_ER_A:   begin op = OP_ERASE; sec = SEC_A; end
            ST_WR_A:   begin op = OP_PROG;  sec = SEC_A; boff = r_q.idx;
                             wd = 8'(r_q.dst >> {r_q.idx, 3'b000}); end
            ST_ER_D:   begin op = OP_ERASE; sec = SEC_D; end
            ST_CP_RD:  begin op = OP_READ;  sec = dsec;  boff = r_q.idx; end
            ST_CP_WR:  begin op = OP_PROG;  sec = SEC_D; boff = r_q.idx; wd = merged; end
            ST_SET_R:  begin op = OP_PROG;  sec = SEC_R; wd = 8'h00; end
            ST_ER_DST: begin op = OP_ERASE; sec = dsec;  end
            ST_BK_RD:  begin op = OP_READ;  sec = SEC_D; boff = r_q.idx; end
            ST_BK_WR:  begin op = OP_PROG;  sec = dsec;  boff = r_q.idx; wd = r_q.rb; end
            ST_ER_R:   begin op = OP_ERASE; sec = SEC_R; end
            default:   begin op = OP_READ;  sec = SEC_R; end
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        bump     = 1'b0;
        fin      = r_q.wt && ((op == OP_READ) ? mem_rvalid : mem_done);

        if (mem_cmd_valid && mem_cmd_ready) r_d.wt = 1'b1;

        if (fin) begin
            r_d.wt = 1'b0;
            unique case (r_q.st)
                ST_BOOT: begin
                    r_d.idx = '0;
                    r_d.dst = '0;
                    r_d.st  = (mem_rdata == 8'hFF) ? ST_IDLE : ST_REC_A;
                end
                ST_REC_A: begin
                    r_d.dst = r_q.dst | (DW'(mem_rdata) << {r_q.idx, 3'b000});
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == LAST_A) begin
                        r_d.idx  = '0;
                        r_d.host = 1'b0;
                        r_d.st   = ST_ER_DST;
                    end
                end
                ST_ER_A: begin r_d.idx = '0; r_d.st = ST_WR_A; end
                ST_WR_A: begin
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == LAST_A) r_d.st = ST_ER_D;
                end
                ST_ER_D:  begin r_d.idx = '0; r_d.st = ST_CP_RD; end
                ST_CP_RD: begin r_d.rb = mem_rdata; r_d.st = ST_CP_WR; end
                ST_CP_WR: begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = (r_q.idx == LAST_B) ? ST_SET_R : ST_CP_RD;
                end
                ST_SET_R:  r_d.st = ST_ER_DST;
                ST_ER_DST: begin r_d.idx = '0; r_d.st = ST_BK_RD; end
                ST_BK_RD:  begin r_d.rb = mem_rdata; r_d.st = ST_BK_WR; end
                ST_BK_WR: begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = (r_q.idx == LAST_B) ? ST_ER_R : ST_BK_RD;
                end
                ST_ER_R: begin
                    bump     = 1'b1;
                    r_d.done = r_q.host;
                    r_d.st   = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        if ((r_q.st == ST_IDLE) && req_valid) begin
            if (bad) begin
                r_d.err = 1'b1;
            end else begin
                r_d.dst              = '0;
                r_d.dst[SECT_W-1:0]  = req_sect;
                r_d.off              = req_off;
                r_d.len              = req_len;
                r_d.dat              = req_data;
                r_d.host             = 1'b1;
                r_d.idx              = '0;
                r_d.st               = ST_ER_A;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_BOOT;
        end else begin
            r_q <= r_d;
        end
    end

    assign upd_busy      = (r_q.st != ST_IDLE);
    assign upd_done      = r_q.done;
    assign upd_err       = r_q.err;
    assign mem_cmd_valid = upd_busy && !r_q.wt;
    assign mem_cmd_op    = op;
    assign mem_cmd_addr  = {sec, boff};
    assign mem_cmd_wdata = wd;

    assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=>
        (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_op) && $stable(mem_cmd_wdata)))
        else $error("command changed while stalled");

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> ($past(upd_busy) && !upd_busy))
        else $error("done without preceding busy");

    assert_err_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |-> (!$past(upd_busy) && !upd_busy && !upd_done))
        else $error("error pulse outside idle");

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && ($past(upd_count) != '1)) |-> (upd_count == $past(upd_count) + 1'b1))
        else $error("counter did not advance with done");

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |=> !upd_err)
        else $error("error pulse longer than one cycle");

endmodule

// File: tb/fsu_sector_updater_test.sv
module fsu_sector_updater_test;
    localparam int SW = 9, SB = 16, N = 8, CW = 16;
    localparam int OW = 4, LW = 4, AW = 13;
    localparam int SEC_R = 509, SEC_A = 510, SEC_D = 511;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [SW-1:0] req_sect = '0;
    logic [OW-1:0] req_off = '0;
    logic [LW-1:0] req_len = '0;
    logic [N*8-1:0] req_data = '0;
    logic          busy, done, err;
    logic [CW-1:0] count;
    logic          cv, cr, mdone, mrvalid;
    logic [1:0]    cop;
    logic [AW-1:0] caddr;
    logic [7:0]    cwd, mrdata;

    fsu_sector_updater #(.SECT_W(SW), .SECT_BYTES(SB), .MAX_N(N), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sect(req_sect),
        .req_off(req_off), .req_len(req_len), .req_data(req_data),
        .upd_busy(busy), .upd_done(done), .upd_err(err), .upd_count(count),
        .mem_cmd_valid(cv), .mem_cmd_ready(cr), .mem_cmd_op(cop),
        .mem_cmd_addr(caddr), .mem_cmd_wdata(cwd), .mem_done(mdone),
        .mem_rvalid(mrvalid), .mem_rdata(mrdata)
    );

    // behavioural memory
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    logic pend = 1'b0, stall = 1'b0, log_clr = 1'b0;
    int   tmr = 0, p_op = 0, p_addr = 0, p_wd = 0, viol = 0;
    int   lop [0:511];
    int   laddr [0:511];
    int   lwd [0:511];
    int   logn = 0;

    function automatic logic [7:0] rd(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    assign cr = !pend && stall;

    always @(posedge clk) begin
        mdone   <= 1'b0;
        mrvalid <= 1'b0;
        stall   <= ~stall;
        if (log_clr) logn <= 0;
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (cv) viol <= viol + 1;
            if (tmr == 0) begin
                pend <= 1'b0;
                if (p_op == 1) begin
                    for (int i = 0; i < SB; i++) mem[(p_addr & ~(SB-1)) + i] = 8'hFF;
                    mdone <= 1'b1;
                end else if (p_op == 2) begin
                    mem[p_addr] = rd(p_addr) & 8'(p_wd);
                    mdone <= 1'b1;
                end else begin
                    mrdata  <= rd(p_addr);
                    mrvalid <= 1'b1;
                end
            end else begin
                tmr <= tmr - 1;
            end
        end else if (cv && cr) begin
            pend   <= 1'b1;
            p_op   <= int'(cop);
            p_addr <= int'(caddr);
            p_wd   <= int'(cwd);
            tmr    <= (cop == 2'd1) ? 3 : 1;
            if (!log_clr && logn < 512) begin
                lop[logn]   <= int'(cop);
                laddr[logn] <= int'(caddr);
                lwd[logn]   <= int'(cwd);
                logn        <= logn + 1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(int v, int k);
        return 8'((v * 16 + k + 1) ^ 8'hA5);
    endfunction

    function automatic int sect_diff(int s, int ref_s);
        int n = 0;
        for (int o = 0; o < SB; o++)
            if (rd(s * SB + o) !== shadow[ref_s * SB + o]) n++;
        return n;
    endfunction

    // {sect[9], off[4], len[4], reject}
    localparam logic [17:0] VEC [9] = '{
        {9'd3,   4'd0,  4'd1, 1'b0},
        {9'd3,   4'd15, 4'd1, 1'b0},
        {9'd7,   4'd4,  4'd8, 1'b0},
        {9'd300, 4'd8,  4'd8, 1'b0},
        {9'd7,   4'd12, 4'd5, 1'b1},
        {9'd2,   4'd0,  4'd0, 1'b1},
        {9'd510, 4'd0,  4'd2, 1'b1},
        {9'd3,   4'd2,  4'd9, 1'b1},
        {9'd3,   4'd3,  4'd4, 1'b0}
    };

    task automatic drive_req(input int s, input int o, input int l, input int v);
        req_sect = SW'(s);
        req_off  = OW'(o);
        req_len  = LW'(l);
        for (int k = 0; k < N; k++) req_data[k*8 +: 8] = dbyte(v, k);
    endtask

    task automatic apply_shadow(input int s, input int o, input int l, input int v);
        for (int k = 0; k < l; k++) shadow[s * SB + o + k] = dbyte(v, k);
    endtask

    task automatic wait_idle(output bit saw_done, output bit saw_err);
        saw_done = 0;
        saw_err  = 0;
        for (int i = 0; i < 20000; i++) begin
            if (done) saw_done = 1;
            if (err) saw_err = 1;
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_cmd(input int op, input int addr);
        for (int i = 0; i < 20000; i++) begin
            if (cv && int'(cop) == op && int'(caddr) == addr) break;
            @(negedge clk);
        end
    endtask

    task automatic power_cycle();
        rst_n   = 1'b0;
        log_clr = 1'b1;
        repeat (4) @(negedge clk);
        log_clr = 1'b0;
    endtask

    function automatic int first_of(int op, int s);
        for (int i = 0; i < logn; i++)
            if (lop[i] == op && (laddr[i] / SB) == s) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        bit sd, se;
        int cnt0;
        foreach (VEC[i]) begin end
        for (int s = 0; s < 301; s++) begin
            if (s == 2 || s == 3 || s == 7 || s == 300)
                for (int o = 0; o < SB; o++) begin
                    mem[s * SB + o]    = 8'((s * 7) ^ (o * 13));
                    shadow[s * SB + o] = 8'((s * 7) ^ (o * 13));
                end
        end

        // reset state and blank-marker start-up
        log_clr = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0 && err == 1'b0 && count == '0, "R1 in reset", int'(busy), 1);
        log_clr = 1'b0;
        rst_n = 1'b1;
        chk(busy == 1'b1 && done == 1'b0 && err == 1'b0 && count == '0, "R1 after reset", int'(count), 0);
        wait_idle(sd, se);
        repeat (3) @(negedge clk);
        chk(logn == 1, "R10 single boot command", logn, 1);
        chk(lop[0] == 0 && laddr[0] == SEC_R * SB, "R1 first command reads marker", laddr[0], SEC_R * SB);
        chk(busy == 1'b0, "R10 idle after blank marker", int'(busy), 0);

        // table walk
        for (int v = 0; v < 9; v++) begin
            int s = int'(VEC[v][17:9]);
            int o = int'(VEC[v][8:5]);
            int l = int'(VEC[v][4:1]);
            bit rej = VEC[v][0];
            int f [8];
            bit ord_ok;
            cnt0 = int'(count);
            log_clr = 1'b1;
            @(negedge clk);
            log_clr = 1'b0;
            drive_req(s, o, l, v);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            if (rej) begin
                chk(err == 1'b1 && busy == 1'b0, "R6 reject pulse", int'(err), 1);
                @(negedge clk);
                chk(err == 1'b0 && busy == 1'b0 && logn == 0, "R6 reject no commands", logn, 0);
                chk(int'(count) == cnt0, "R6 reject keeps count", int'(count), cnt0);
            end else begin
                chk(busy == 1'b1 && err == 1'b0, "R7 busy after accept", int'(busy), 1);
                wait_idle(sd, se);
                chk(sd && !se && done && !busy, "R7 done pulse with busy low", int'(done), 1);
                @(negedge clk);
                chk(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
                apply_shadow(s, o, l, v);
                chk(sect_diff(s, s) == 0, "R3 destination content", sect_diff(s, s), 0);
                chk(sect_diff(SEC_D, s) == 0, "R3 image content", sect_diff(SEC_D, s), 0);
                chk(int'(rd(SEC_A * SB)) == (s & 255) && int'(rd(SEC_A * SB + 1)) == (s >> 8),
                    "R5 journal index", int'(rd(SEC_A * SB)) + 256 * int'(rd(SEC_A * SB + 1)), s);
                chk(rd(SEC_R * SB) == 8'hFF, "R4 marker cleared", int'(rd(SEC_R * SB)), 255);
                chk(int'(count) == cnt0 + 1, "R8 count per update", int'(count), cnt0 + 1);
                f[0] = first_of(1, SEC_A); f[1] = first_of(2, SEC_A);
                f[2] = first_of(1, SEC_D); f[3] = first_of(2, SEC_D);
                f[4] = first_of(2, SEC_R); f[5] = first_of(1, s);
                f[6] = first_of(2, s);     f[7] = first_of(1, SEC_R);
                ord_ok = (f[0] == 0) && (f[7] == logn - 1);
                for (int i = 1; i < 8; i++) if (f[i] <= f[i-1]) ord_ok = 0;
                chk(ord_ok, "R2 command order", f[7], logn - 1);
                chk(f[4] >= 0 && lwd[f[4]] == 0 && laddr[f[4]] == SEC_R * SB,
                    "R4 marker programmed to zero", f[4] >= 0 ? lwd[f[4]] : -1, 0);
            end
        end

        // cut before commit: destination must stay old
        drive_req(7, 0, 3, 20);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cmd(2, SEC_D * SB + 3);
        power_cycle();
        rst_n = 1'b1;
        wait_idle(sd, se);
        repeat (3) @(negedge clk);
        chk(sect_diff(7, 7) == 0, "R10 uncommitted update leaves destination", sect_diff(7, 7), 0);
        chk(logn == 1 && count == '0, "R10 only marker read after cut", logn, 1);

        // cut after commit, with host request held during recovery
        drive_req(3, 10, 4, 21);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        apply_shadow(3, 10, 4, 21);
        wait_cmd(2, 3 * SB + 5);
        power_cycle();
        drive_req(2, 0, 2, 23);
        req_valid = 1'b1;
        rst_n = 1'b1;
        sd = 0; se = 0;
        for (int i = 0; i < 4; i++) begin
            if (done || err) sd = 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_idle(cnt0 == 0 ? sd : sd, se);
        chk(!sd && !se, "R11 request during recovery ignored", int'(sd) + int'(se), 0);
        chk(sect_diff(2, 2) == 0, "R11 held request left its sector", sect_diff(2, 2), 0);
        chk(sect_diff(3, 3) == 0, "R9 resumed destination", sect_diff(3, 3), 0);
        chk(rd(SEC_R * SB) == 8'hFF, "R9 marker erased after resume", int'(rd(SEC_R * SB)), 255);
        chk(int'(count) == 1, "R8 resumed update counted", int'(count), 1);
        chk(first_of(2, SEC_A) < 0 && first_of(2, SEC_D) < 0, "R9 no journal or image programs",
            first_of(2, SEC_D), -1);
        chk(lop[1] == 0 && laddr[1] == SEC_A * SB, "R9 journal read after marker", laddr[1], SEC_A * SB);

        // partially programmed marker
        power_cycle();
        mem[SEC_R * SB]     = 8'h7F;
        mem[SEC_A * SB]     = 8'h2C;
        mem[SEC_A * SB + 1] = 8'h01;
        for (int o = 0; o < SB; o++) begin
            mem[SEC_D * SB + o] = 8'(8'h40 + o);
            shadow[300 * SB + o] = 8'(8'h40 + o);
        end
        rst_n = 1'b1;
        wait_idle(sd, se);
        repeat (3) @(negedge clk);
        chk(sect_diff(300, 300) == 0, "R9 partial marker resumes", sect_diff(300, 300), 0);
        chk(rd(SEC_R * SB) == 8'hFF && count == 1, "R9 partial marker cleared", int'(count), 1);

        // normal update after recovery
        drive_req(2, 0, 8, 22);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle(sd, se);
        apply_shadow(2, 0, 8, 22);
        chk(sd && sect_diff(2, 2) == 0, "R3 full-width update", sect_diff(2, 2), 0);
        chk(int'(count) == 2, "R8 count continues", int'(count), 2);
        chk(viol == 0, "R12 single outstanding command", viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule